// File: doc/BRIEF.md
# Ramped FSK Frequency Sweep Controller

This block produces the frequency tuning word that drives a phase accumulator when two-tone frequency keying is softened into a sweep. It does not jump from the low tone to the high tone. It walks the tuning word from the lower endpoint toward the upper one, or back, by a programmable increment. Each step waits for a pulse from a reloadable down-counting rate timer that runs on the system clock with no prescaler. The sweep stops exactly on an endpoint and stays there for as long as the direction select is unchanged. The dwell at either end can therefore be far longer than the time spent on any intermediate frequency.

The host loads the low word into `lo_word` and the high word into `hi_word`. The low word must not exceed the high word. The host also sets the step size in `step_word` and the timer reload in `rate_load`. While `sweep_en` is low, the block acts as a plain two-tone switch: the output takes the selected endpoint one clock later. When `sweep_en` is high, `dir_up` picks the sweep direction.

A small state machine tracks where the sweep stands. Its states are:
- `SW_DIRECT`: sweep disabled, or just enabled.
- `SW_RISE`: stepping upward.
- `SW_FALL`: stepping downward.
- `SW_TOP`: resting on the high word.
- `SW_BOTTOM`: resting on the low word.

Its transitions are:
- Any state goes to `SW_DIRECT` when `sweep_en` is low.
- With `dir_up` high, the machine goes to `SW_TOP` once the next word equals the high word. Otherwise it goes to `SW_RISE`.
- With `dir_up` low, the machine goes to `SW_BOTTOM` once the next word equals the low word. Otherwise it goes to `SW_FALL`.

Top module: `rfsk_sweep`

## Requirements
- R1: Synchronous active-low reset sets the output word to `lo_word`, loads the rate timer with `rate_load` and places the machine in `SW_DIRECT`. If the sweep is enabled at release, the first step lands after `rate_load`+1 rising clock edges.
- R2: While `sweep_en` is low, each clock edge copies `hi_word` (when `dir_up` is 1) or `lo_word` (when `dir_up` is 0) to `tw_out`, so the output follows the select with one clock of latency.
- R3: While the sweep is enabled, the timer pulses once every `rate_load`+1 clocks, and `tw_out` changes only on a pulse. While the sweep is disabled, the timer is held at `rate_load`, so the first step after enabling lands `rate_load`+1 edges later. A `rate_load` of 0 gives a step on every clock.
- R4: On a pulse with `dir_up` = 1 and the word below `hi_word`, the word grows by `step_word`.
- R5: On a pulse with `dir_up` = 0 and the word above `lo_word`, the word shrinks by `step_word`.
- R6: A rising step that would reach or pass `hi_word` lands exactly on `hi_word`, even if the step does not divide the span evenly or the sum overflows the word width.
- R7: A falling step that would reach or pass `lo_word` lands exactly on `lo_word`, with no wrap below zero.
- R8: Once an endpoint is reached with the select unchanged, the word rests there through any number of timer pulses. It leaves only when `dir_up` reverses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the rate timer counts on every edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sweep_en | input | 1 | 1 = swept transitions, 0 = direct switching |
| dir_up | input | 1 | Direction select: 1 = toward high word, 0 = toward low word |
| lo_word | input | FW_W | Lower endpoint tuning word |
| hi_word | input | FW_W | Upper endpoint tuning word |
| step_word | input | FW_W | Increment applied on each timer pulse |
| rate_load | input | RATE_W | Timer reload value; step spacing is this plus one |
| tw_out | output | FW_W | Current tuning word to the phase accumulator |

## Verification
The bench builds the block with an 8-bit tuning word and a 4-bit rate field. This makes the full word range reachable, including the carry out of the top bit when a step of 255 is added near the high end. It sweeps several endpoint pairs against step sizes from 1 to 255 and reload values of 0, 3 and 15. Each pair is run up to the high word and back down to the low word, and every clock is compared against an arithmetic model of the timer phase and the clamped step.

// File: rtl/rfsk_pkg.sv
package rfsk_pkg;

    typedef enum logic [2:0] {
        SW_DIRECT = 3'd0,
        SW_RISE   = 3'd1,
        SW_FALL   = 3'd2,
        SW_TOP    = 3'd3,
        SW_BOTTOM = 3'd4
    } sweep_st_e;

endpackage

// File: rtl/rfsk_rate_timer.sv
module rfsk_rate_timer #(
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [RATE_W-1:0] cnt;

    // pulse on the cycle the count sits at zero, suppressed while held
    assign tick = ~hold & (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= rate;
        end else if (cnt == '0) begin
            cnt <= rate;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/rfsk_step.sv
module rfsk_step #(
    parameter int FW_W = 48
) (
    input  logic [FW_W-1:0] cur,
    input  logic [FW_W-1:0] f_lo,
    input  logic [FW_W-1:0] f_hi,
    input  logic [FW_W-1:0] delta,
    output logic [FW_W-1:0] up_w,
    output logic [FW_W-1:0] dn_w
);

    localparam int EXT_W = FW_W + 1;

    logic [EXT_W-1:0] up_sum;
    logic [EXT_W-1:0] lo_reach;

    // one extra bit keeps the carry so a large step cannot wrap past the top
    assign up_sum   = {1'b0, cur}  + {1'b0, delta};
    assign lo_reach = {1'b0, f_lo} + {1'b0, delta};

    assign up_w = (up_sum >= {1'b0, f_hi}) ? f_hi : up_sum[FW_W-1:0];
    assign dn_w = ({1'b0, cur} <= lo_reach) ? f_lo : (cur - delta);

endmodule

// File: rtl/rfsk_sweep.sv
module rfsk_sweep
    import rfsk_pkg::*;
#(
    parameter int FW_W   = 48,
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_en,
    input  logic              dir_up,
    input  logic [FW_W-1:0]   lo_word,
    input  logic [FW_W-1:0]   hi_word,
    input  logic [FW_W-1:0]   step_word,
    input  logic [RATE_W-1:0] rate_load,
    output logic [FW_W-1:0]   tw_out
);

    sweep_st_e       state;
    sweep_st_e       state_nx;
    logic [FW_W-1:0] cur;
    logic [FW_W-1:0] cur_nx;
    logic [FW_W-1:0] up_w;
    logic [FW_W-1:0] dn_w;
    logic            tick;

    rfsk_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (~sweep_en),
        .rate  (rate_load),
        .tick  (tick)
    );

    rfsk_step #(.FW_W(FW_W)) u_step (
        .cur   (cur),
        .f_lo  (lo_word),
        .f_hi  (hi_word),
        .delta (step_word),
        .up_w  (up_w),
        .dn_w  (dn_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_DIRECT;
            cur   <= lo_word;
        end else begin
            state <= state_nx;
            cur   <= cur_nx;
        end
    end

    // output word per state
    always_comb begin
        cur_nx = cur;
        if (!sweep_en) begin
            cur_nx = dir_up ? hi_word : lo_word;
        end else begin
            unique case (state)
                SW_TOP:    if (tick && !dir_up) cur_nx = dn_w;
                SW_BOTTOM: if (tick &&  dir_up) cur_nx = up_w;
                SW_DIRECT,
                SW_RISE,
                SW_FALL:   if (tick) cur_nx = dir_up ? up_w : dn_w;
                default:   cur_nx = cur;
            endcase
        end
    end

    // transitions
    always_comb begin
        if (!sweep_en) begin
            state_nx = SW_DIRECT;
        end else if (dir_up) begin
            state_nx = (cur_nx == hi_word) ? SW_TOP : SW_RISE;
        end else begin
            state_nx = (cur_nx == lo_word) ? SW_BOTTOM : SW_FALL;
        end
    end

    assign tw_out = cur;

endmodule

// File: rtl/rfsk_sweep_chk.sv
module rfsk_sweep_chk
    import rfsk_pkg::*;
#(
    parameter int FW_W   = 48,
    parameter int RATE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sweep_en,
    input logic              dir_up,
    input logic [FW_W-1:0]   lo_word,
    input logic [FW_W-1:0]   hi_word,
    input logic [RATE_W-1:0] rate_load,
    input logic [FW_W-1:0]   tw_out,
    input logic              tick,
    input sweep_st_e         state
);

    AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_en |=> tw_out == ($past(dir_up) ? $past(hi_word) : $past(lo_word))); // R2

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !tick) |=> $stable(tw_out)); // R3

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sweep_en && rate_load != '0 && $stable(rate_load)) |=> !tick); // R3

    AST_RISE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && dir_up && tw_out <= hi_word) |=> tw_out >= $past(tw_out)); // R4

    AST_FALL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !dir_up && tw_out >= lo_word) |=> tw_out <= $past(tw_out)); // R5

    AST_UPPER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && dir_up && tw_out <= hi_word) |=> tw_out <= $past(hi_word)); // R6

    AST_LOWER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && !dir_up && tw_out >= lo_word) |=> tw_out >= $past(lo_word)); // R7

    AST_DWELL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_TOP && sweep_en && dir_up) |=> $stable(tw_out)); // R8

    AST_DWELL_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_BOTTOM && sweep_en && !dir_up) |=> $stable(tw_out)); // R8

endmodule

bind rfsk_sweep rfsk_sweep_chk #(.FW_W(FW_W), .RATE_W(RATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sweep_en  (sweep_en),
    .dir_up    (dir_up),
    .lo_word   (lo_word),
    .hi_word   (hi_word),
    .rate_load (rate_load),
    .tw_out    (tw_out),
    .tick      (tick),
    .state     (state)
);

// File: tb/sim_rfsk_sweep.sv
module sim_rfsk_sweep;

    localparam int FW_W   = 8;
    localparam int RATE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sweep_en = 1'b0;
    logic              dir_up = 1'b0;
    logic [FW_W-1:0]   lo_word = '0;
    logic [FW_W-1:0]   hi_word = '0;
    logic [FW_W-1:0]   step_word = '0;
    logic [RATE_W-1:0] rate_load = '0;
    logic [FW_W-1:0]   tw_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk; // 50 MHz

    rfsk_sweep #(.FW_W(FW_W), .RATE_W(RATE_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_en  (sweep_en),
        .dir_up    (dir_up),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .step_word (step_word),
        .rate_load (rate_load),
        .tw_out    (tw_out)
    );

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: tw_out=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_step(input int e, input bit up, input int lo, input int hi, input int d);
        if (up) return (e + d >= hi) ? hi : e + d;
        return (e <= lo + d) ? lo : e - d;
    endfunction

    task automatic tick_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // runs one direction until the endpoint is reached and held; c is the timer phase
    task automatic sweep_leg(input bit up, input int lo, input int hi, input int d,
                             input int r, inout int e, inout int c);
        int dwell = 0;
        int tgt = up ? hi : lo;
        dir_up = up;
        while (!(e == tgt && dwell >= 2 * (r + 1))) begin
            bit stepped;
            tick_cycle();
            c++;
            stepped = (c % (r + 1) == 0);
            if (stepped) e = model_step(e, up, lo, hi, d);
            if (e == tgt) dwell++;
            if (stepped && e == tgt && dwell == 1) check(int'(tw_out), e, up ? "R6" : "R7");
            else if (stepped && e != tgt)          check(int'(tw_out), e, up ? "R4" : "R5");
            else if (e == tgt)                     check(int'(tw_out), e, "R8");
            else                                   check(int'(tw_out), e, "R3");
        end
    endtask

    task automatic run_case(input int lo, input int hi, input int d, input int r);
        int e;
        int c;
        sweep_en  = 1'b0;
        dir_up    = 1'b0;
        lo_word   = FW_W'(lo);
        hi_word   = FW_W'(hi);
        step_word = FW_W'(d);
        rate_load = RATE_W'(r);
        tick_cycle();
        check(int'(tw_out), lo, "R2");
        dir_up = 1'b1;
        tick_cycle();
        check(int'(tw_out), hi, "R2");
        dir_up = 1'b0;
        tick_cycle();
        check(int'(tw_out), lo, "R2");
        sweep_en = 1'b1;
        e = lo;
        c = 0;
        sweep_leg(1'b1, lo, hi, d, r, e, c);
        sweep_leg(1'b0, lo, hi, d, r, e, c);
        sweep_en = 1'b0;
    endtask

    initial begin
        int lo_tab [3] = '{10, 0, 40};
        int hi_tab [3] = '{200, 255, 41};
        int d_tab  [4] = '{1, 5, 64, 255};
        int r_tab  [3] = '{0, 3, 15};
        int e;
        // reset with sweep already enabled
        sweep_en  = 1'b1;
        dir_up    = 1'b1;
        lo_word   = 8'd10;
        hi_word   = 8'd200;
        step_word = 8'd5;
        rate_load = 4'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(int'(tw_out), 10, "R1");
        rst_n = 1'b1;
        e = 10;
        for (int k = 1; k <= 8; k++) begin
            tick_cycle();
            if (k % 4 == 0) e += 5;
            check(int'(tw_out), e, "R1");
        end
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 4; j++)
                for (int m = 0; m < 3; m++)
                    run_case(lo_tab[i], hi_tab[i], d_tab[j], r_tab[m]);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule